// File: doc/BRIEF.md
# Four-Bit Input Port Conditioner

This block conditions the four input pins of a small microcontroller's general-purpose input port. Every pin first passes through a two-flop synchronizer. After that the pin's level goes to four places:

- a debouncer that accepts a new level only after it has been stable for a number of slow sample strobes;
- a per-pin path selector that picks either the debounced level or the synchronized raw level, and can invert it;
- an edge detector that turns rising edges of the selected signal into latched interrupt requests;
- a counter-event output that drives the clock of an external 10-bit event counter from pin 0 or pin 3.

Two branch-test flags always carry the debounced levels of pins 0 and 1. The path-select and polarity settings have no effect on them.

A small register file holds the per-pin control bits and gives read access to the live pin levels and the pending requests. Pull-up and pull-down options are fixed per pin by parameters. A software inhibit bit per pin decides whether the fixed option is actually enabled.

There are two state machines, one instance of each per pin:

- **Debouncer.** It has the states STEADY and CHANGING.
  - STEADY→CHANGING is taken on a sample strobe when the input differs from the accepted level.
  - CHANGING→STEADY (bounce) is taken on a strobe when the input is back at the accepted level.
  - CHANGING→STEADY (accept) is taken on the Nth consecutive differing strobe, and updates the level.
- **Edge tracker.** It has the states LOW and HIGH.
  - LOW→HIGH (rise) is taken when the selected signal is 1. This transition raises the edge pulse.
  - HIGH→LOW (fall) is taken when the selected signal is 0.

Top module: `inport_cond`

## Requirements
- R1: Reading register address 0 returns the current levels of `pin_i` combinationally, with bit n being pin n.
- R2: A debounced level changes only after the synchronized pin has differed from it on DEB_TICKS (default 3) consecutive `sample_tick_i` strobes. A strobe on which the pin matches the accepted level restarts the count. The debounced levels reset to 0.
- R3: `test_flag_o[0]` is the debounced level of pin 0 and `test_flag_o[1]` is the debounced level of pin 1. Neither depends on the path-select or polarity registers.
- R4: For the interrupt and counter paths, each pin's conditioned signal is built from two register bits. Bit n of the path-select register (address 1) picks the debounced level when 1 and the synchronized raw level when 0. Bit n of the polarity register (address 2) inverts that signal when 1.
- R5: A rising edge of pin n's conditioned signal sets pending bit n only while mask bit n (address 3) is 1. When the mask bit is 0, nothing is stored. The mask bits reset to 0.
- R6: A pending bit stays set until software writes 1 to that bit at address 5. The pending bits are readable at address 5 and on `irq_pend_o`.
- R7: `irq_o` is 1 exactly when some pending bit is set whose mask bit is also 1.
- R8: Bit 0 of address 6 picks the counter source: 0 selects pin 0 and 1 selects pin 3. `cnt_evt_o` gives one pulse, one cycle long, for each rising edge of the selected pin's conditioned signal, whatever the mask setting.
- R9: `pullup_en_o[n]` is the parameter bit PULLUP_OPT[n] gated by the inhibit bit n (address 4) being 0. `pulldn_en_o[n]` is PULLDN_OPT[n] gated the same way.
- R10: A pin with both PULLUP_OPT and PULLDN_OPT set is illegal. For such a pin both enables stay 0 and `opt_err_o` is 1.
- R11: The registers at addresses 1 to 4 and address 6 reset to 0 and read back what was written. Writes take effect at the clock edge on which `reg_wr_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 4 | Port pins (asynchronous) |
| sample_tick_i | input | 1 | Slow debounce sample strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 4 | Register write data |
| reg_rdata_o | output | 4 | Register read data |
| irq_pend_o | output | 4 | Pending interrupt request bits |
| irq_o | output | 1 | Combined interrupt request |
| test_flag_o | output | 2 | Debounced branch-test flags (pins 0 and 1) |
| cnt_evt_o | output | 1 | Event pulse for the external counter |
| pullup_en_o | output | 4 | Pull-up enables |
| pulldn_en_o | output | 4 | Pull-down enables |
| opt_err_o | output | 1 | Illegal pull option combination present |

## Verification
The hardest situation to reach from the ports is a debouncer that bounces partway through a count. The pin must return to the accepted level for exactly one strobe after some, but not all, of the required strobes have been seen. Directed sequences of pin changes and counted strobes create this case and then show that the full count has to start again.

A second hard case is an interrupt edge that is produced by changing the polarity register rather than the pin. Register writes with the pins held steady reach it.

Randomized pin patterns, under random polarity, mask and counter-source settings, are checked against a bench model of the edge, pending and event-count behaviour.

// File: rtl/inport_pkg.sv
package inport_pkg;

    typedef enum logic [0:0] {
        DB_STEADY   = 1'b0,
        DB_CHANGING = 1'b1
    } db_state_e;

    typedef enum logic [0:0] {
        EG_LOW  = 1'b0,
        EG_HIGH = 1'b1
    } edge_state_e;

    localparam logic [2:0] A_PINS   = 3'd0;
    localparam logic [2:0] A_DEBSEL = 3'd1;
    localparam logic [2:0] A_INV    = 3'd2;
    localparam logic [2:0] A_MASK   = 3'd3;
    localparam logic [2:0] A_INHIB  = 3'd4;
    localparam logic [2:0] A_PEND   = 3'd5;
    localparam logic [2:0] A_SRC    = 3'd6;

endpackage

// File: rtl/inport_debounce.sv
module inport_debounce
    import inport_pkg::*;
#(
    parameter int TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic lvl_o
);

    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    db_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          lvl_q, lvl_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DB_STEADY;
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lvl_q   <= lvl_d;
        end
    end

    // next state and accepted level
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lvl_d   = lvl_q;
        if (tick) begin
            unique case (state_q)
                DB_STEADY: begin
                    if (din != lvl_q) begin
                        if (TICKS <= 1) begin
                            lvl_d = din;
                        end else begin
                            state_d = DB_CHANGING;
                            cnt_d   = CW'(1);
                        end
                    end
                end
                DB_CHANGING: begin
                    if (din == lvl_q) begin
                        state_d = DB_STEADY;
                        cnt_d   = '0;
                    end else if (cnt_q == LAST) begin
                        state_d = DB_STEADY;
                        cnt_d   = '0;
                        lvl_d   = din;
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
                default: begin
                    state_d = DB_STEADY;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        lvl_o = lvl_q;
    end

endmodule

// File: rtl/inport_edge.sv
module inport_edge
    import inport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise_o
);

    edge_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EG_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        unique case (state_q)
            EG_LOW:  state_d = sig ? EG_HIGH : EG_LOW;
            EG_HIGH: state_d = sig ? EG_HIGH : EG_LOW;
            default: state_d = EG_LOW;
        endcase
    end

    // outputs
    always_comb begin
        rise_o = (state_q == EG_LOW) && sig;
    end

endmodule

// File: rtl/inport_regs.sv
module inport_regs
    import inport_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [2:0]      addr,
    input  logic [NPIN-1:0] wdata,
    input  logic [NPIN-1:0] pins,
    input  logic [NPIN-1:0] pend,
    output logic [NPIN-1:0] debsel_o,
    output logic [NPIN-1:0] inv_o,
    output logic [NPIN-1:0] mask_o,
    output logic [NPIN-1:0] inhib_o,
    output logic            src_o,
    output logic [NPIN-1:0] clr_o,
    output logic [NPIN-1:0] rdata_o
);

    logic [NPIN-1:0] debsel_q, inv_q, mask_q, inhib_q;
    logic            src_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debsel_q <= '0;
            inv_q    <= '0;
            mask_q   <= '0;
            inhib_q  <= '0;
            src_q    <= 1'b0;
        end else if (wr) begin
            if (addr == A_DEBSEL) debsel_q <= wdata;
            if (addr == A_INV)    inv_q    <= wdata;
            if (addr == A_MASK)   mask_q   <= wdata;
            if (addr == A_INHIB)  inhib_q  <= wdata;
            if (addr == A_SRC)    src_q    <= wdata[0];
        end
    end

    always_comb begin
        clr_o = (wr && addr == A_PEND) ? wdata : '0;
    end

    always_comb begin
        unique case (addr)
            A_PINS:   rdata_o = pins;
            A_DEBSEL: rdata_o = debsel_q;
            A_INV:    rdata_o = inv_q;
            A_MASK:   rdata_o = mask_q;
            A_INHIB:  rdata_o = inhib_q;
            A_PEND:   rdata_o = pend;
            A_SRC:    rdata_o = {{(NPIN-1){1'b0}}, src_q};
            default:  rdata_o = '0;
        endcase
    end

    assign debsel_o = debsel_q;
    assign inv_o    = inv_q;
    assign mask_o   = mask_q;
    assign inhib_o  = inhib_q;
    assign src_o    = src_q;

endmodule

// File: rtl/inport_cond.sv
module inport_cond
    import inport_pkg::*;
#(
    parameter int             NPIN       = 4,
    parameter int             DEB_TICKS  = 3,
    parameter logic [NPIN-1:0] PULLUP_OPT = 4'b0011,
    parameter logic [NPIN-1:0] PULLDN_OPT = 4'b0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic            sample_tick_i,
    input  logic            reg_wr_i,
    input  logic [2:0]      reg_addr_i,
    input  logic [NPIN-1:0] reg_wdata_i,
    output logic [NPIN-1:0] reg_rdata_o,
    output logic [NPIN-1:0] irq_pend_o,
    output logic            irq_o,
    output logic [1:0]      test_flag_o,
    output logic            cnt_evt_o,
    output logic [NPIN-1:0] pullup_en_o,
    output logic [NPIN-1:0] pulldn_en_o,
    output logic            opt_err_o
);

    localparam logic [NPIN-1:0] CONFLICT = PULLUP_OPT & PULLDN_OPT;

    logic [NPIN-1:0] sync1_q, sync2_q;
    logic [NPIN-1:0] deb_lvl, cond_sig, rise;
    logic [NPIN-1:0] debsel_q, inv_q, mask_q, inhib_q, clr_vec;
    logic [NPIN-1:0] pend_q;
    logic            src_q, evt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pin_i;
            sync2_q <= sync1_q;
        end
    end

    inport_regs #(.NPIN(NPIN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr_i),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .pins     (pin_i),
        .pend     (pend_q),
        .debsel_o (debsel_q),
        .inv_o    (inv_q),
        .mask_o   (mask_q),
        .inhib_o  (inhib_q),
        .src_o    (src_q),
        .clr_o    (clr_vec),
        .rdata_o  (reg_rdata_o)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        inport_debounce #(.TICKS(DEB_TICKS)) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (sample_tick_i),
            .din   (sync2_q[i]),
            .lvl_o (deb_lvl[i])
        );

        assign cond_sig[i] = (debsel_q[i] ? deb_lvl[i] : sync2_q[i]) ^ inv_q[i];

        inport_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig    (cond_sig[i]),
            .rise_o (rise[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            evt_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | (rise & mask_q);
            evt_q  <= src_q ? rise[3] : rise[0];
        end
    end

    assign irq_pend_o  = pend_q;
    assign irq_o       = |(pend_q & mask_q);
    assign test_flag_o = deb_lvl[1:0];
    assign cnt_evt_o   = evt_q;
    assign pullup_en_o = PULLUP_OPT & ~CONFLICT & ~inhib_q;
    assign pulldn_en_o = PULLDN_OPT & ~CONFLICT & ~inhib_q;
    assign opt_err_o   = |CONFLICT;

endmodule

// File: rtl/inport_cond_chk.sv
module inport_cond_chk #(
    parameter int NPIN = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sample_tick_i,
    input logic [NPIN-1:0] irq_pend_o,
    input logic            irq_o,
    input logic [1:0]      test_flag_o,
    input logic            cnt_evt_o,
    input logic [NPIN-1:0] pullup_en_o,
    input logic [NPIN-1:0] pulldn_en_o,
    input logic [NPIN-1:0] mask_q,
    input logic [NPIN-1:0] inhib_q,
    input logic [NPIN-1:0] clr_vec
);

    property p_flag_on_tick;
        @(posedge clk) disable iff (!rst_n)
        !$stable(test_flag_o) |-> $past(sample_tick_i);
    endproperty

    property p_mask_nostore;
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_pend_o & ~$past(irq_pend_o) & ~$past(mask_q)) == '0);
    endproperty

    property p_pend_hold;
        @(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(irq_pend_o) & ~irq_pend_o & ~$past(clr_vec)) == '0);
    endproperty

    property p_irq_source;
        @(posedge clk) disable iff (!rst_n)
        irq_o |-> ((irq_pend_o & mask_q) != '0);
    endproperty

    property p_evt_single;
        @(posedge clk) disable iff (!rst_n)
        cnt_evt_o |=> !cnt_evt_o;
    endproperty

    property p_inhibit_off;
        @(posedge clk) disable iff (!rst_n)
        ((pullup_en_o | pulldn_en_o) & inhib_q) == '0;
    endproperty

    property p_pull_excl;
        @(posedge clk) disable iff (!rst_n)
        (pullup_en_o & pulldn_en_o) == '0;
    endproperty

    AST_FLAG_ON_TICK:  assert property (p_flag_on_tick);   // R2
    AST_MASK_NOSTORE:  assert property (p_mask_nostore);   // R5
    AST_PEND_HOLD:     assert property (p_pend_hold);      // R6
    AST_IRQ_SOURCE:    assert property (p_irq_source);     // R7
    AST_EVT_SINGLE:    assert property (p_evt_single);     // R8
    AST_INHIBIT_OFF:   assert property (p_inhibit_off);    // R9
    AST_PULL_EXCL:     assert property (p_pull_excl);      // R10

endmodule

bind inport_cond inport_cond_chk #(.NPIN(NPIN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_tick_i (sample_tick_i),
    .irq_pend_o    (irq_pend_o),
    .irq_o         (irq_o),
    .test_flag_o   (test_flag_o),
    .cnt_evt_o     (cnt_evt_o),
    .pullup_en_o   (pullup_en_o),
    .pulldn_en_o   (pulldn_en_o),
    .mask_q        (mask_q),
    .inhib_q       (inhib_q),
    .clr_vec       (clr_vec)
);

// File: tb/inport_cond_test.sv
module inport_cond_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_i = '0;
    logic       sample_tick_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [2:0] reg_addr_i = '0;
    logic [3:0] reg_wdata_i = '0;
    logic [3:0] reg_rdata_o, irq_pend_o, pullup_en_o, pulldn_en_o;
    logic       irq_o, cnt_evt_o, opt_err_o;
    logic [1:0] test_flag_o;

    logic [3:0] c_rdata, c_pend, c_pu, c_pd;
    logic       c_irq, c_evt, c_err;
    logic [1:0] c_flag;

    int nchk = 0;
    int nfail = 0;
    int evt_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inport_cond uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sample_tick_i(sample_tick_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_pend_o(irq_pend_o), .irq_o(irq_o),
        .test_flag_o(test_flag_o), .cnt_evt_o(cnt_evt_o),
        .pullup_en_o(pullup_en_o), .pulldn_en_o(pulldn_en_o), .opt_err_o(opt_err_o)
    );

    inport_cond #(.PULLUP_OPT(4'b1001), .PULLDN_OPT(4'b1010)) uut_conflict (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sample_tick_i(1'b0),
        .reg_wr_i(1'b0), .reg_addr_i(3'd0), .reg_wdata_i(4'd0),
        .reg_rdata_o(c_rdata), .irq_pend_o(c_pend), .irq_o(c_irq),
        .test_flag_o(c_flag), .cnt_evt_o(c_evt),
        .pullup_en_o(c_pu), .pulldn_en_o(c_pd), .opt_err_o(c_err)
    );

    always @(negedge clk) if (rst_n && cnt_evt_o) evt_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [3:0] d);
        @(negedge clk);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) sample_tick_i = 1'b1;
            @(negedge clk) sample_tick_i = 1'b0;
        end
    endtask

    function automatic logic [3:0] exp_pull(input logic [3:0] opt, input logic [3:0] inh);
        return opt & ~inh;
    endfunction

    function automatic logic [3:0] rises(input logic [3:0] prev, input logic [3:0] cur);
        return ~prev & cur;
    endfunction

    initial begin
        logic [3:0] d;
        logic [3:0] inv, mask, prev, cur, r, exp_pend, clr;
        logic       src;
        int         exp_evt, base;

        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);

        // reset state
        for (int a = 1; a <= 6; a++) begin
            rd(3'(a), d);
            check("R11 reset value", d, 4'h0);
        end
        check("R5 reset irq", irq_o, 1'b0);
        check("R2 reset flags", test_flag_o, 2'b00);

        // R11 read-back
        wr(3'd1, 4'hA); rd(3'd1, d); check("R11 debsel readback", d, 4'hA);
        wr(3'd6, 4'h1); rd(3'd6, d); check("R11 src readback", d, 4'h1);
        wr(3'd1, 4'h0); wr(3'd6, 4'h0);

        // R1 raw read
        for (int k = 0; k < 4; k++) begin
            @(negedge clk) pin_i = 4'($urandom);
            reg_addr_i = 3'd0;
            #1 check("R1 raw pin read", reg_rdata_o, pin_i);
        end
        pin_i = 4'h0;
        wait_cyc(4);

        // R9 pulls
        for (int k = 0; k < 6; k++) begin
            d = (k == 0) ? 4'h0 : 4'($urandom);
            wr(3'd4, d);
            #1;
            check("R9 pullup enable", pullup_en_o, exp_pull(4'b0011, d));
            check("R9 pulldown enable", pulldn_en_o, exp_pull(4'b0100, d));
        end
        wr(3'd4, 4'h0);

        // R10 illegal option combination
        check("R10 error flag", c_err, 1'b1);
        check("R10 pullups", c_pu, 4'b0001);
        check("R10 pulldowns", c_pd, 4'b0010);

        // R2 debounce count
        pin_i = 4'b0001; wait_cyc(4);
        ticks(2); wait_cyc(2);
        check("R2 two strobes not enough", test_flag_o, 2'b00);
        ticks(1); wait_cyc(2);
        check("R2 third strobe accepts", test_flag_o, 2'b01);
        // bounce mid-count restarts
        pin_i = 4'b0000; wait_cyc(4); ticks(2);
        pin_i = 4'b0001; wait_cyc(4); ticks(1);
        pin_i = 4'b0000; wait_cyc(4); ticks(2); wait_cyc(2);
        check("R2 bounce restarts count", test_flag_o, 2'b01);
        ticks(1); wait_cyc(2);
        check("R2 accept after restart", test_flag_o, 2'b00);

        // R3 flags ignore path and polarity settings
        wr(3'd2, 4'hF); wr(3'd1, 4'h0); wait_cyc(2);
        check("R3 flag0 ignores polarity", test_flag_o, 2'b00);
        pin_i = 4'b0010; wait_cyc(4); ticks(3); wait_cyc(2);
        check("R3 flag1 debounced not inverted", test_flag_o, 2'b10);

        // R4 / R5 debounced path on pin 2
        wr(3'd2, 4'h0); wait_cyc(4);
        wr(3'd5, 4'hF);
        wr(3'd3, 4'b0100); wr(3'd1, 4'b0100);
        pin_i = 4'b0110; wait_cyc(5);
        check("R4 debounced path waits", irq_pend_o, 4'b0000);
        ticks(3); wait_cyc(3);
        check("R5 pend after debounce", irq_pend_o, 4'b0100);
        check("R7 irq asserted", irq_o, 1'b1);
        // R4 edge via polarity change on pin 3
        wr(3'd3, 4'b1100); wr(3'd2, 4'b1000); wait_cyc(3);
        check("R4 inverted pin3 edge", irq_pend_o, 4'b1100);
        // R7 masking hides pending
        wr(3'd3, 4'b0000); wait_cyc(1);
        check("R7 irq masked", irq_o, 1'b0);
        rd(3'd5, d);
        check("R6 pend held while masked", d, 4'b1100);
        wr(3'd3, 4'b1100); wait_cyc(1);
        check("R7 irq unmasked", irq_o, 1'b1);
        // R6 clear
        wr(3'd5, 4'b0100); wait_cyc(1);
        check("R6 partial clear", irq_pend_o, 4'b1000);
        wr(3'd5, 4'hF); wait_cyc(1);
        check("R6 full clear", irq_pend_o, 4'b0000);
        check("R7 irq cleared", irq_o, 1'b0);

        // R8 counter source
        wr(3'd3, 4'h0); wr(3'd2, 4'h0); wr(3'd1, 4'h0); wr(3'd6, 4'h1);
        pin_i = 4'h0; wait_cyc(6);
        base = evt_seen;
        for (int k = 0; k < 2; k++) begin
            pin_i = 4'b0001; wait_cyc(5); pin_i = 4'b0000; wait_cyc(5);
        end
        check("R8 pin0 ignored when pin3 selected", evt_seen - base, 0);
        for (int k = 0; k < 2; k++) begin
            pin_i = 4'b1000; wait_cyc(5); pin_i = 4'b0000; wait_cyc(5);
        end
        check("R8 pin3 pulses", evt_seen - base, 2);
        wr(3'd6, 4'h0); wait_cyc(2);
        base = evt_seen;
        pin_i = 4'b0001; wait_cyc(5); pin_i = 4'b0000; wait_cyc(5);
        check("R8 pin0 pulse", evt_seen - base, 1);

        // randomized blocks, direct path
        void'($urandom(32'h5EED_0042));
        for (int b = 0; b < 8; b++) begin
            inv  = 4'($urandom);
            mask = 4'($urandom);
            src  = 1'($urandom);
            wr(3'd2, inv); wr(3'd6, {3'b000, src}); wait_cyc(6);
            wr(3'd5, 4'hF); wr(3'd3, mask); wait_cyc(2);
            exp_pend = 4'h0;
            prev = pin_i ^ inv;
            exp_evt = 0;
            base = evt_seen;
            for (int s = 0; s < 40; s++) begin
                @(negedge clk) pin_i = 4'($urandom);
                wait_cyc(5);
                cur = pin_i ^ inv;
                r = rises(prev, cur);
                exp_pend = exp_pend | (r & mask);
                exp_evt += src ? int'(r[3]) : int'(r[0]);
                prev = cur;
                check("R5 random pending", irq_pend_o, exp_pend);
                check("R7 random irq", irq_o, |(exp_pend & mask));
                check("R8 random event count", evt_seen - base, exp_evt);
                clr = 4'($urandom);
                wr(3'd5, clr);
                exp_pend = exp_pend & ~clr;
                wait_cyc(1);
                check("R6 random clear", irq_pend_o, exp_pend);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule